// File: doc/BRIEF.md
# Multistage Omega Network Switch Fabric

This block carries packets from P source ports to P destination ports through log2(P) ranks of two-by-two switching elements. A perfect-shuffle wire pattern joins the ranks. Each source offers a valid flag, a destination index and a payload. No central controller exists. Every element reads one bit of the destination tag on each of its inputs and sets itself from those bits alone.

The network is blocking. Two packets can ask an element for the same output in the same cycle. A per-element rotating pointer then picks the winner, and the loser is dropped from the fabric for that cycle. The loser's source sees its ready line low, so it keeps its request and tries again on a later cycle.

The path from the sources through all ranks is combinational. The destination side is a single register rank, so a granted packet appears at its destination port one clock edge after it is offered.

Top module: `omega_fabric`

## Requirements
- R1: Line j entering a rank is driven by line j rotated right by one bit, which makes the shuffle a one-bit left rotation of the line index. At rank k (k = 0 first), an element sends a packet to its even (upper) output when destination bit log2(P)-1-k is 0, and to its odd (lower) output when that bit is 1. As a result, a valid packet that meets no conflict leaves on the output port equal to its destination, with its payload unchanged.
- R2: Suppose every source is valid and source i targets (i + c) mod P for a single constant c. Then no conflict occurs, all ready lines are high in that cycle, and all P packets are delivered.
- R3: A packet granted in a cycle appears on `out_valid`/`out_data` after the next rising clock edge. Outputs that receive no packet that cycle show `out_valid` low.
- R4: `in_ready[i]` is combinational in the cycle of the request. It is high when source i is not valid, or when its packet reaches an output. It is low when the packet loses a conflict anywhere in the fabric.
- R5: At most one packet is delivered to each output per cycle. A source whose packet loses is not delivered.
- R6: Each element has a one-bit priority pointer. When it is 0 the upper (even) input wins a conflict, and when it is 1 the lower input wins. Every conflict at that element inverts the pointer.
- R7: A source with `in_valid` low takes no part in arbitration. It causes no conflict and never inverts a pointer.
- R8: Reset (`rst_n` low) clears `out_valid` to 0 and sets every priority pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | P | Per-source request flag |
| in_dest | input | P*A | Per-source destination index, source i in bits [i*A +: A] |
| in_data | input | P*W | Per-source payload, source i in bits [i*W +: W] |
| in_ready | output | P | Per-source accept, combinational |
| out_valid | output | P | Per-destination delivery flag, registered |
| out_data | output | P*W | Per-destination payload, destination o in bits [o*W +: W] |

## Verification
`in_ready` answers in the same cycle as the request. The bench therefore drives inputs just after a falling edge and samples ready 1 ns later, before the rising edge. Delivered packets are due one rising edge later, so outputs are sampled at the following falling edge, and only then are the inputs changed. Arbitration history is counted edge by edge: conflicts are repeated on consecutive cycles so that the expected winner alternates, and a reset between two conflicts shows the pointer returning to the upper input.

// File: rtl/omega_fabric.sv
module omega_fabric #(
  parameter int P = 8,
  parameter int W = 16,
  parameter int A = $clog2(P)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [P-1:0]   in_valid,
  input  logic [P*A-1:0] in_dest,
  input  logic [P*W-1:0] in_data,
  output logic [P-1:0]   in_ready,
  output logic [P-1:0]   out_valid,
  output logic [P*W-1:0] out_data
);
  localparam int N = A;
  localparam int E = P / 2;

  logic [P-1:0] lv [0:N];
  logic [A-1:0] ld [0:N][P];
  logic [W-1:0] lp [0:N][P];
  logic [A-1:0] ls [0:N][P];
  logic [P-1:0] hit;

  for (genvar i = 0; i < P; i++) begin : g_in
    assign lv[0][i] = in_valid[i];
    assign ld[0][i] = in_dest[i*A +: A];
    assign lp[0][i] = in_data[i*W +: W];
    assign ls[0][i] = A'(i);
  end

  for (genvar k = 0; k < N; k++) begin : g_stage
    for (genvar e = 0; e < E; e++) begin : g_elem
      localparam int JU = 2 * e;
      localparam int JL = 2 * e + 1;
      localparam int IU = (JU >> 1) | ((JU & 1) << (A - 1));
      localparam int IL = (JL >> 1) | ((JL & 1) << (A - 1));

      logic vu, vl, bu, bl, clash, pri, gu, gl, su, sl;

      assign vu    = lv[k][IU];
      assign vl    = lv[k][IL];
      assign bu    = ld[k][IU][A-1-k];
      assign bl    = ld[k][IL][A-1-k];
      assign clash = vu & vl & (bu == bl);
      assign gu    = vu & (~clash | ~pri);
      assign gl    = vl & (~clash | pri);
      assign su    = gu & ~bu;
      assign sl    = gu & bu;

      assign lv[k+1][JU] = su | (gl & ~bl);
      assign lv[k+1][JL] = sl | (gl & bl);
      assign ld[k+1][JU] = su ? ld[k][IU] : ld[k][IL];
      assign ld[k+1][JL] = sl ? ld[k][IU] : ld[k][IL];
      assign lp[k+1][JU] = su ? lp[k][IU] : lp[k][IL];
      assign lp[k+1][JL] = sl ? lp[k][IU] : lp[k][IL];
      assign ls[k+1][JU] = su ? ls[k][IU] : ls[k][IL];
      assign ls[k+1][JL] = sl ? ls[k][IU] : ls[k][IL];

      always_ff @(posedge clk) begin
        if (!rst_n)     pri <= 1'b0;
        else if (clash) pri <= ~pri;
      end
    end
  end

  always_comb begin
    hit = '0;
    for (int o = 0; o < P; o++)
      if (lv[N][o]) hit[ls[N][o]] = 1'b1;
  end

  assign in_ready = ~in_valid | hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= lv[N];
      for (int o = 0; o < P; o++) out_data[o*W +: W] <= lp[N][o];
    end
  end
endmodule

// File: rtl/omega_fabric_chk.sv
module omega_fabric_chk #(
  parameter int P = 8,
  parameter int W = 16,
  parameter int A = $clog2(P)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [P-1:0]   in_valid,
  input logic [P*A-1:0] in_dest,
  input logic [P*W-1:0] in_data,
  input logic [P-1:0]   in_ready,
  input logic [P-1:0]   out_valid,
  input logic [P*W-1:0] out_data
);
  logic [P-1:0] gmask;
  int           gcnt;
  logic [W-1:0] gdata [P];
  logic         is_shift;

  always_comb begin
    gmask = '0;
    gcnt  = 0;
    for (int o = 0; o < P; o++) gdata[o] = '0;
    is_shift = &in_valid;
    for (int i = 0; i < P; i++) begin
      if (in_valid[i] && in_ready[i]) begin
        gmask[in_dest[i*A +: A]] = 1'b1;
        gdata[in_dest[i*A +: A]] = in_data[i*W +: W];
        gcnt++;
      end
      if (in_dest[i*A +: A] != A'(in_dest[A-1:0] + A'(i))) is_shift = 1'b0;
    end
  end

  assert_unique_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gcnt == $countones(gmask));

  assert_shift_all_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_shift |-> in_ready == '1);

  assert_out_follows_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(gmask));

  for (genvar o = 0; o < P; o++) begin : g_out
    assert_payload_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_valid[o]) |-> out_data[o*W +: W] == $past(gdata[o]));
  end
endmodule

bind omega_fabric omega_fabric_chk #(.P(P), .W(W), .A(A)) i_chk (.*);

// File: tb/test_omega_fabric.sv
module test_omega_fabric;
  localparam int P = 8;
  localparam int W = 16;
  localparam int A = 3;
  localparam logic [A-1:0] SHIFTS [0:7] = '{3'd0, 3'd3, 3'd5, 3'd1, 3'd7, 3'd2, 3'd6, 3'd4};
  localparam logic [P-1:0] SHIFT_READY = 8'hFF;

  logic clk = 0, rst_n = 0;
  logic [P-1:0]   in_valid = '0;
  logic [P*A-1:0] in_dest = '0;
  logic [P*W-1:0] in_data = '0;
  logic [P-1:0]   in_ready, out_valid;
  logic [P*W-1:0] out_data;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  omega_fabric #(.P(P), .W(W), .A(A)) i_omega_fabric (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear();
    in_valid = '0; in_dest = '0; in_data = '0;
  endtask

  task automatic req(int s, int d, logic [W-1:0] p);
    in_valid[s] = 1'b1;
    in_dest[s*A +: A] = A'(d);
    in_data[s*W +: W] = p;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clash(logic [P-1:0] exp_ready, logic [W-1:0] exp_data, string tag);
    clear();
    req(0, 5, 16'hAAAA); req(1, 5, 16'hBBBB);
    #1 chk({tag, " ready"}, in_ready, exp_ready);
    tick();
    chk({tag, " out_valid"}, out_valid, 8'h20);
    chk({tag, " winner"}, out_data[5*W +: W], exp_data);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    #1 chk("R8 out_valid in reset", out_valid, 0);
    chk("R4 idle ready", in_ready, 8'hFF);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      clear();
      for (int i = 0; i < P; i++) req(i, (i + SHIFTS[v]) % P, {8'(v), 8'(i)});
      #1 chk("R2 shift ready", in_ready, SHIFT_READY);
      tick();
      chk("R3 shift out_valid", out_valid, 8'hFF);
      for (int o = 0; o < P; o++)
        chk("R1 payload at dest", out_data[o*W +: W], {8'(v), 8'((o - SHIFTS[v] + P) % P)});
    end

    clear();
    #1 chk("R4 idle ready after shifts", in_ready, 8'hFF);
    tick();
    chk("R3 no request no output", out_valid, 0);

    clear();
    req(2, 6, 16'h1234); req(7, 0, 16'h5678); req(4, 3, 16'h9ABC);
    #1 chk("R4 partial ready", in_ready, 8'hFF);
    tick();
    chk("R3 partial out_valid", out_valid, 8'b0100_1001);
    chk("R1 partial dest6", out_data[6*W +: W], 16'h1234);
    chk("R1 partial dest0", out_data[0*W +: W], 16'h5678);
    chk("R1 partial dest3", out_data[3*W +: W], 16'h9ABC);

    clash(8'b1111_1101, 16'hAAAA, "R6 first conflict upper wins");
    clash(8'b1111_1110, 16'hBBBB, "R6 second conflict lower wins");
    clash(8'b1111_1101, 16'hAAAA, "R5 third conflict");

    clear();
    in_dest[0 +: A] = 3'd5; in_data[0 +: W] = 16'hAAAA;
    req(1, 5, 16'hBBBB);
    #1 chk("R7 invalid no conflict ready", in_ready, 8'hFF);
    tick();
    chk("R7 invalid out_valid", out_valid, 8'h20);
    chk("R7 invalid data", out_data[5*W +: W], 16'hBBBB);
    clash(8'b1111_1110, 16'hBBBB, "R7 pointer untouched");

    clash(8'b1111_1101, 16'hAAAA, "R6 pointer back to upper");
    clear();
    rst_n = 0;
    tick();
    chk("R8 out_valid after reset", out_valid, 0);
    rst_n = 1;
    clash(8'b1111_1101, 16'hAAAA, "R8 pointer reset to upper");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule